// File: doc/BRIEF.md
# SPI Master Error Monitor

This block sits beside the shift engine of an SPI master and watches each word transfer for faults. It compares every bit the controller drives against the value read back from the same line at the receive point. When parity is enabled it checks the parity bit that follows each received word. It times the slave's ready line twice: once after chip select goes active, where the slave must answer, and once after the last bit, where the slave must let go. Each fault sets a sticky flag. Software can clear any flag by writing 1 to it, and all flags clear while the monitor enable is low.

A handshake timeout also raises a one-cycle chip-select abort request, which the chip-select logic uses to release the select line at once. Both handshake windows are programmable counts of system-clock cycles. Each count is loaded when its window opens. The release window only opens after the last bit, so the desync flag can appear after the word's receive-complete event. Software that reads the status very soon after that event can therefore see a desync result that is not yet final. A length-error pulse from the shift engine is latched under the same clear rules. A single interrupt line reports any flag whose enable bit is set.

Top module: `spi_err_mon`

## Requirements
- R1: A `rx_strobe` pulse with `tx_bit` different from `line_bit` sets flag bit 0 (bit error) at that clock edge. A pulse with equal values sets nothing.
- R2: On a `word_done` pulse with `par_en`=1, the expected parity bit is XOR(`rx_word`) XOR `par_odd`. Here `par_odd`=0 selects even parity and 1 selects odd parity. If `rx_par` differs from the expected bit, flag bit 1 (parity error) sets. With `par_en`=0 no parity flag is raised.
- R3: A `cs_start` pulse opens a timeout window of `to_limit`+1 following cycles, provided `master_mode`=1 and `hs_en`=1. If `slv_rdy` is high in none of those cycles, flag bit 2 (timeout) sets at the edge ending the last cycle. `cs_abort` is high for exactly the one cycle after that edge. If `slv_rdy` is seen high inside the window, including in its last cycle, nothing is raised.
- R4: A `last_bit` pulse opens a release window of `t2e_dly`+1 following cycles, provided `master_mode`=1 and `hs_en`=1. If `slv_rdy` stays high through the whole window, flag bit 3 (desync) sets. If `slv_rdy` is seen low inside the window, nothing is raised.
- R5: With `master_mode`=0 or `hs_en`=0, neither window runs. No timeout flag, desync flag or `cs_abort` is produced.
- R6: A cycle with `clr_wr`=1 clears every flag whose bit in `clr_mask` is 1. Bits written as 0 are left unchanged.
- R7: While `mon_en`=0, all flags read 0 from the next edge on and no fault can set them.
- R8: If a fault sets a flag in the same cycle that `clr_wr` clears it, the flag ends up set.
- R9: A `len_err` pulse sets flag bit 4 (length error), which obeys R6 to R8.
- R10: Flag bit 5 is reserved and always reads 0.
- R11: `err_irq` is 1 exactly when some flag bit i (i from 0 to 4) and `irq_mask` bit i are both 1.
- R12: After reset all flags, `cs_abort` and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_en | input | 1 | Monitor enable; low clears and holds all flags |
| master_mode | input | 1 | 1 = master, enables handshake checks |
| hs_en | input | 1 | Ready-line handshake function enabled |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| rx_strobe | input | 1 | Receive-point pulse for the bit readback |
| tx_bit | input | 1 | Bit intended on the driven line |
| line_bit | input | 1 | Value read back from the driven line |
| word_done | input | 1 | Received word and parity bit valid |
| rx_word | input | DATA_W | Received data word |
| rx_par | input | 1 | Received parity bit |
| cs_start | input | 1 | Chip select became active |
| last_bit | input | 1 | Last bit of the word transferred |
| slv_rdy | input | 1 | Slave ready line, active high |
| to_limit | input | CNT_W | Timeout window count |
| t2e_dly | input | CNT_W | Transfer-to-release window count |
| len_err | input | 1 | Length-error pulse from the shift engine |
| clr_wr | input | 1 | Write strobe for flag clearing |
| clr_mask | input | 5 | Write-one-to-clear mask, flag bits 0 to 4 |
| irq_mask | input | 5 | Per-flag interrupt enables, flag bits 0 to 4 |
| flags | output | 6 | Sticky flags; bit 5 reserved zero |
| cs_abort | output | 1 | One-cycle request to release chip select |
| err_irq | output | 1 | Combined error interrupt |

## Verification
A hardware fault can set a flag in the same cycle that software writes 1 to clear it. The bench provokes this by pulsing `rx_strobe` with mismatched bits in the same cycle as `clr_wr` with mask bit 0 set. It then expects bit 0 to stay 1. In that same write it also clears another flag with no fault pending, to confirm that the clear still works on that bit. The window boundaries are also exercised: the ready line is moved in the final cycle of each window, and the flag must not be raised.

// File: rtl/spi_err_pkg.sv
// Package: flag positions and counts shared by the error monitor.
// Assumes flags 0..NACT-1 are live and the top bit is reserved.
package spi_err_pkg;
    localparam int NFLAG   = 6;
    localparam int NACT    = 5;
    localparam int FLG_BIT = 0;
    localparam int FLG_PAR = 1;
    localparam int FLG_TMO = 2;
    localparam int FLG_DSY = 3;
    localparam int FLG_LEN = 4;
endpackage

// File: rtl/spi_win_timer.sv
// Window timer: opens on start, counts limit+1 cycles, and pulses
// expire combinationally in the last cycle if ok was never seen.
// Assumes kill has priority and a start while busy restarts the window.
module spi_win_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             start,
    input  logic [CNT_W-1:0] limit,
    input  logic             ok,
    output logic             expire
);
    logic             busy;
    logic [CNT_W-1:0] cnt;

    // Window state: load on start, count down, close on ok or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (kill) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= limit;
        end else if (busy) begin
            if (ok || cnt == '0) busy <= 1'b0;
            else                 cnt  <= cnt - 1'b1;
        end
    end

    // Expiry in the final window cycle with no acceptable answer.
    assign expire = busy && !ok && (cnt == '0) && !kill && !start;
endmodule

// File: rtl/spi_err_check.sv
// Data-path checks: readback bit mismatch and parity mismatch.
// Assumes strobes are single-cycle and data is valid with them.
module spi_err_check #(
    parameter int DATA_W = 8
) (
    input  logic              rx_strobe,
    input  logic              tx_bit,
    input  logic              line_bit,
    input  logic              word_done,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_par,
    output logic              bit_fault,
    output logic              par_fault
);
    logic exp_par;

    // Expected parity bit for the selected sense.
    assign exp_par = (^rx_word) ^ par_odd;

    // Fault pulses for the flag register.
    always_comb begin
        bit_fault = rx_strobe & (tx_bit ^ line_bit);
        par_fault = word_done & par_en & (rx_par ^ exp_par);
    end
endmodule

// File: rtl/spi_err_flags.sv
// Sticky flag register with write-one-to-clear, set priority over
// clear, and a global enable that clears and holds all bits.
module spi_err_flags #(
    parameter int NACT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NACT-1:0] set,
    input  logic            clr_wr,
    input  logic [NACT-1:0] clr_mask,
    output logic [NACT-1:0] flags_q
);
    genvar i;
    generate
        for (i = 0; i < NACT; i++) begin : g_flag
            // One sticky bit: reset/disable clear, set beats clear.
            always_ff @(posedge clk) begin
                if (!rst_n || !en)          flags_q[i] <= 1'b0;
                else if (set[i])            flags_q[i] <= 1'b1;
                else if (clr_wr && clr_mask[i]) flags_q[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_err_mon.sv
// Top: SPI master error monitor. Combines readback/parity checks,
// two handshake window timers, the sticky flag register, the abort
// request and the masked interrupt. Handshake checks run only in
// master mode with the ready-line function enabled.
module spi_err_mon
    import spi_err_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en,
    input  logic              master_mode,
    input  logic              hs_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rx_strobe,
    input  logic              tx_bit,
    input  logic              line_bit,
    input  logic              word_done,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_par,
    input  logic              cs_start,
    input  logic              last_bit,
    input  logic              slv_rdy,
    input  logic [CNT_W-1:0]  to_limit,
    input  logic [CNT_W-1:0]  t2e_dly,
    input  logic              len_err,
    input  logic              clr_wr,
    input  logic [NACT-1:0]   clr_mask,
    input  logic [NACT-1:0]   irq_mask,
    output logic [NFLAG-1:0]  flags,
    output logic              cs_abort,
    output logic              err_irq
);
    logic            hs_kill;
    logic            bit_fault, par_fault, tmo_fault, dsy_fault;
    logic [NACT-1:0] set_vec;
    logic [NACT-1:0] flags_q;
    logic            abort_q;

    // Handshake windows stop outside master mode or when disabled.
    assign hs_kill = !mon_en || !master_mode || !hs_en;

    spi_err_check #(.DATA_W(DATA_W)) u_check (
        .rx_strobe (rx_strobe),
        .tx_bit    (tx_bit),
        .line_bit  (line_bit),
        .word_done (word_done),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .rx_word   (rx_word),
        .rx_par    (rx_par),
        .bit_fault (bit_fault),
        .par_fault (par_fault)
    );

    // Timeout: waits for ready to rise after chip select.
    spi_win_timer #(.CNT_W(CNT_W)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill   (hs_kill),
        .start  (cs_start),
        .limit  (to_limit),
        .ok     (slv_rdy),
        .expire (tmo_fault)
    );

    // Desync: waits for ready to fall after the last bit.
    spi_win_timer #(.CNT_W(CNT_W)) u_dsy (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill   (hs_kill),
        .start  (last_bit),
        .limit  (t2e_dly),
        .ok     (!slv_rdy),
        .expire (dsy_fault)
    );

    // Gather fault pulses into flag positions.
    always_comb begin
        set_vec          = '0;
        set_vec[FLG_BIT] = bit_fault;
        set_vec[FLG_PAR] = par_fault;
        set_vec[FLG_TMO] = tmo_fault;
        set_vec[FLG_DSY] = dsy_fault;
        set_vec[FLG_LEN] = len_err;
    end

    spi_err_flags #(.NACT(NACT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mon_en),
        .set      (set_vec),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .flags_q  (flags_q)
    );

    // One-cycle chip-select abort aligned with the timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= tmo_fault;
    end

    assign flags    = {{(NFLAG-NACT){1'b0}}, flags_q};
    assign cs_abort = abort_q;
    assign err_irq  = |(flags_q & irq_mask);
endmodule

// File: rtl/spi_err_mon_chk.sv
// Checker for spi_err_mon, attached by bind below.
module spi_err_mon_chk
    import spi_err_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mon_en,
    input logic             master_mode,
    input logic             clr_wr,
    input logic             rx_strobe,
    input logic             tx_bit,
    input logic             line_bit,
    input logic [NFLAG-1:0] flags,
    input logic             cs_abort,
    input logic             err_irq
);
    // R1: readback mismatch sets the bit-error flag.
    a_r1_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && rx_strobe && (tx_bit != line_bit)) |=> flags[FLG_BIT]);

    // R3: an abort request comes with the timeout flag, in master mode.
    a_r3_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cs_abort |-> (flags[FLG_TMO] && $past(master_mode)));

    // R3: abort is a single-cycle pulse.
    a_r3_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cs_abort |=> !cs_abort);

    // R6: without a clear write and with enable, set flags stay set.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && !clr_wr) |=> ((flags & $past(flags)) == $past(flags)));

    // R7: disable clears everything on the next edge.
    a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (flags == '0));

    // R10: reserved bit is zero.
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[NFLAG-1]);

    // R11: interrupt only with some flag present.
    a_r11_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (flags != '0));
endmodule

bind spi_err_mon spi_err_mon_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mon_en      (mon_en),
    .master_mode (master_mode),
    .clr_wr      (clr_wr),
    .rx_strobe   (rx_strobe),
    .tx_bit      (tx_bit),
    .line_bit    (line_bit),
    .flags       (flags),
    .cs_abort    (cs_abort),
    .err_irq     (err_irq)
);

// File: tb/tb_spi_err_mon.sv
// Directed bench for spi_err_mon; inputs change and outputs are
// sampled on the falling clock edge.
module tb_spi_err_mon;
    localparam int DW = 8;
    localparam int CW = 16;
    localparam int WN = 3;

    logic clk = 0, rst_n = 0;
    logic mon_en = 1, master_mode = 1, hs_en = 1, par_en = 0, par_odd = 0;
    logic rx_strobe = 0, tx_bit = 0, line_bit = 0, word_done = 0;
    logic [DW-1:0] rx_word = '0;
    logic rx_par = 0, cs_start = 0, last_bit = 0, slv_rdy = 0, len_err = 0;
    logic [CW-1:0] to_limit = CW'(WN), t2e_dly = CW'(WN);
    logic clr_wr = 0;
    logic [4:0] clr_mask = '0, irq_mask = 5'h1f;
    logic [5:0] flags;
    logic cs_abort, err_irq;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_err_mon #(.DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .master_mode(master_mode),
        .hs_en(hs_en), .par_en(par_en), .par_odd(par_odd),
        .rx_strobe(rx_strobe), .tx_bit(tx_bit), .line_bit(line_bit),
        .word_done(word_done), .rx_word(rx_word), .rx_par(rx_par),
        .cs_start(cs_start), .last_bit(last_bit), .slv_rdy(slv_rdy),
        .to_limit(to_limit), .t2e_dly(t2e_dly), .len_err(len_err),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_mask(irq_mask),
        .flags(flags), .cs_abort(cs_abort), .err_irq(err_irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_wr = 1; clr_mask = 5'h1f;
        @(negedge clk);
        clr_wr = 0; clr_mask = '0;
    endtask

    task automatic pulse_bit(input logic t, input logic l);
        rx_strobe = 1; tx_bit = t; line_bit = l;
        @(negedge clk);
        rx_strobe = 0;
    endtask

    task automatic pulse_word(input logic [DW-1:0] w, input logic p);
        word_done = 1; rx_word = w; rx_par = p;
        @(negedge clk);
        word_done = 0;
    endtask

    task automatic t_reset();
        chk("R12 flags", 32'(flags), 0);
        chk("R12 abort", 32'(cs_abort), 0);
        chk("R12 irq", 32'(err_irq), 0);
    endtask

    task automatic t_bit();
        pulse_bit(1, 1);
        chk("R1 match", 32'(flags[0]), 0);
        pulse_bit(1, 0);
        chk("R1 mismatch", 32'(flags[0]), 1);
        chk("R10 reserved", 32'(flags[5]), 0);
        clr_wr = 1; clr_mask = 5'b11110;
        @(negedge clk); clr_wr = 0; clr_mask = '0;
        chk("R6 zero no effect", 32'(flags[0]), 1);
        clr_wr = 1; clr_mask = 5'b00001;
        @(negedge clk); clr_wr = 0; clr_mask = '0;
        chk("R6 w1c", 32'(flags[0]), 0);
    endtask

    task automatic t_par();
        par_en = 1; par_odd = 0;
        pulse_word(8'b1011_0000, 1);
        chk("R2 even ok", 32'(flags[1]), 0);
        pulse_word(8'b1011_0000, 0);
        chk("R2 even bad", 32'(flags[1]), 1);
        clear_all();
        par_odd = 1;
        pulse_word(8'b1011_0000, 0);
        chk("R2 odd ok", 32'(flags[1]), 0);
        pulse_word(8'b1011_0000, 1);
        chk("R2 odd bad", 32'(flags[1]), 1);
        clear_all();
        par_en = 0;
        pulse_word(8'b1011_0000, 1);
        chk("R2 disabled", 32'(flags[1]), 0);
        par_odd = 0;
    endtask

    // Timeout window; rdy raised in the last window cycle if in_time.
    task automatic t_tmo(input bit in_time);
        slv_rdy = 0; cs_start = 1;
        @(negedge clk); cs_start = 0;
        for (int i = 1; i <= WN; i++) begin
            @(negedge clk);
            if (i == WN && in_time) slv_rdy = 1;
        end
        chk("R3 before end", 32'(flags[2]), 0);
        @(negedge clk);
        chk("R3 flag", 32'(flags[2]), in_time ? 0 : 1);
        chk("R3 abort", 32'(cs_abort), in_time ? 0 : 1);
        @(negedge clk);
        chk("R3 abort pulse", 32'(cs_abort), 0);
        slv_rdy = 0;
        clear_all();
    endtask

    // Release window; rdy dropped in the last window cycle if in_time.
    task automatic t_dsy(input bit in_time);
        slv_rdy = 1; last_bit = 1;
        @(negedge clk); last_bit = 0;
        for (int i = 1; i <= WN; i++) begin
            @(negedge clk);
            if (i == WN && in_time) slv_rdy = 0;
        end
        chk("R4 before end", 32'(flags[3]), 0);
        @(negedge clk);
        chk("R4 flag", 32'(flags[3]), in_time ? 0 : 1);
        slv_rdy = 0;
        clear_all();
    endtask

    task automatic t_suppress(input logic mm, input logic he);
        logic seen;
        seen = 0;
        master_mode = mm; hs_en = he; slv_rdy = 0; cs_start = 1;
        @(negedge clk); cs_start = 0;
        for (int i = 0; i < WN + 3; i++) begin
            @(negedge clk);
            seen |= cs_abort;
        end
        chk("R5 no timeout", 32'(flags[2]), 0);
        chk("R5 no abort", 32'(seen), 0);
        slv_rdy = 1; last_bit = 1;
        @(negedge clk); last_bit = 0;
        repeat (WN + 3) @(negedge clk);
        chk("R5 no desync", 32'(flags[3]), 0);
        slv_rdy = 0; master_mode = 1; hs_en = 1;
    endtask

    task automatic t_len();
        len_err = 1;
        @(negedge clk); len_err = 0;
        chk("R9 len set", 32'(flags[4]), 1);
        clear_all();
        chk("R9 len clear", 32'(flags[4]), 0);
    endtask

    task automatic t_setwins();
        len_err = 1;
        @(negedge clk); len_err = 0;
        rx_strobe = 1; tx_bit = 0; line_bit = 1;
        clr_wr = 1; clr_mask = 5'b10001;
        @(negedge clk);
        rx_strobe = 0; clr_wr = 0; clr_mask = '0;
        chk("R8 set wins", 32'(flags[0]), 1);
        chk("R8 other cleared", 32'(flags[4]), 0);
        clear_all();
    endtask

    task automatic t_enable();
        pulse_bit(1, 0);
        len_err = 1; @(negedge clk); len_err = 0;
        chk("R7 pre", 32'(flags), 32'h11);
        mon_en = 0;
        @(negedge clk);
        chk("R7 cleared", 32'(flags), 0);
        pulse_bit(0, 1);
        chk("R7 held", 32'(flags), 0);
        mon_en = 1;
        @(negedge clk);
        chk("R7 after", 32'(flags), 0);
    endtask

    task automatic t_irq();
        irq_mask = 5'b11110;
        pulse_bit(1, 0);
        chk("R11 masked", 32'(err_irq), 0);
        irq_mask = 5'b00001;
        #1;
        chk("R11 enabled", 32'(err_irq), 1);
        clear_all();
        chk("R11 none", 32'(err_irq), 0);
        irq_mask = 5'h1f;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bit();
        t_par();
        t_tmo(0);
        t_tmo(1);
        t_dsy(0);
        t_dsy(1);
        t_suppress(0, 1);
        t_suppress(1, 0);
        t_len();
        t_setwins();
        t_enable();
        t_irq();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule